// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block orders comparator events into a trigger for an on-chip debug unit. Once armed, it steps through up to three intermediate states. In each of these states, the highest-priority channel that reports a hit picks the next state from a table that software has loaded. When the sequence reaches its final state, the block issues a trace trigger. It holds that state for exactly one clock and then disarms itself.

A software trigger strobe jumps straight to the final state from any intermediate state. A channel can also be set to raise a breakpoint request on each of its hits. Such a channel works apart from the sequence and takes no part in choosing the next state. The comparators, the trace store, the CPU halt path and the register decode all sit outside this block. Configuration reaches it as plain ports.

Top module: `dbg_seq`

## Requirements
- R1: From idle (status 000), a cycle with `arm_set_i` high and `arm_clr_i` low moves the sequencer to state 1 (status 001) on the next clock. Without `arm_set_i`, it stays idle.
- R2: In state s (1 to 3), the winning channel c selects the next state from a table. When `nxt_fin_i[(s-1)*NCH+c]` is set, the next state is final. Otherwise the code `nxt_code_i[((s-1)*NCH+c)*2 +: 2]` applies: 00 keeps the state, 01 selects state 1, 10 selects state 2 and 11 selects state 3. Any state from 1 to 3 may follow any other.
- R3: The final state (status 100) lasts exactly one clock. The sequencer then returns to idle and `armed_o` falls. This holds whatever the trace and breakpoint settings are.
- R4: A cycle with `arm_clr_i` high returns the sequencer to idle on the next clock, from any state. This has priority over every other input.
- R5: When several sequencing channels hit in the same cycle, the lowest-numbered channel wins. Its table entry alone decides the next state, even when that entry is "stay".
- R6: In states 1 to 3, `sw_trig_i` moves the sequencer to the final state on the next clock, whatever the channel hits are.
- R7: A channel counts as hit when either its forced-hit input or its tagged-hit input is high.
- R8: In states 1 to 3, a hit on a channel whose `brk_en_i` bit is set raises `brk_req_o` for one clock on the next cycle. Such a channel is left out of sequence arbitration, so other channels can still drive transitions in the same cycle. In idle and final, `brk_req_o` stays low.
- R9: `state_o` reports the current state: 000 for idle, 001 to 011 for states 1 to 3, and 100 for final. `armed_o` is high exactly when the status is not 000. After reset, the status is 000 and all pulse outputs are low.
- R10: `trace_trig_o` is a one-clock pulse for each entry to the final state. With `trace_align_i` low, the pulse comes in the same cycle that the status shows 100. With `trace_align_i` high, it comes one cycle later, in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_set_i | input | 1 | Arm strobe |
| arm_clr_i | input | 1 | Disarm strobe |
| sw_trig_i | input | 1 | Software trigger strobe |
| force_hit_i | input | NCH | Forced hit, per channel |
| tag_hit_i | input | NCH | Tagged hit, per channel |
| brk_en_i | input | NCH | Breakpoint enable, per channel |
| nxt_code_i | input | 3*NCH*2 | Next-state code, per state and per channel |
| nxt_fin_i | input | 3*NCH | Final-state select, per state and per channel |
| trace_align_i | input | 1 | Trace trigger timing select |
| state_o | output | 3 | Current state status |
| trace_trig_o | output | 1 | Trace trigger pulse |
| brk_req_o | output | 1 | Breakpoint request pulse |
| armed_o | output | 1 | Sequencer armed |

## Verification
Directed walks route single hits through each table code, including "stay" and the final select, using both forced and tagged hits. These walks separate the decoding of the table from the combining of the two hit inputs. Simultaneous hits on two channels, with entries that disagree, show whether the priority order is right. Adding a breakpoint-enabled channel to the same cycle shows whether that channel is kept out of arbitration. Software triggers, disarm strobes that arrive mid-sequence and both trace alignment settings each test one override path. A long random run then mixes all the inputs against a behavioural model that is compared on every clock.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_e;

  localparam int unsigned NMID   = 3;
  localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/dbg_seq_arb.sv
module dbg_seq_arb #(
  parameter int unsigned NCH  = 3,
  localparam int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  req_i,
  output logic            win_valid_o,
  output logic [IDXW-1:0] win_idx_o
);
  // lowest index wins: scan downwards so the last assignment is the lowest
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/dbg_seq_route.sv
module dbg_seq_route
  import dbg_seq_pkg::*;
#(
  parameter int unsigned NCH  = 3,
  localparam int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned NENT = NMID * NCH
) (
  input  seq_state_e           cur_i,
  input  logic                 win_valid_i,
  input  logic [IDXW-1:0]      win_idx_i,
  input  logic [NENT*CODE_W-1:0] code_i,
  input  logic [NENT-1:0]      fin_i,
  output seq_state_e           dest_o
);
  logic [NENT-1:0]   hit_ent;
  logic [CODE_W-1:0] masked [NENT];
  logic [CODE_W-1:0] code_sel;
  logic              fin_sel;

  for (genvar s = 0; s < NMID; s++) begin : g_state
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign hit_ent[s*NCH+c] = win_valid_i
                              && (cur_i == seq_state_e'(3'(s + 1)))
                              && (win_idx_i == IDXW'(c));
      assign masked[s*NCH+c]  = code_i[(s*NCH+c)*CODE_W +: CODE_W]
                              & {CODE_W{hit_ent[s*NCH+c]}};
    end
  end

  always_comb begin
    code_sel = '0;
    for (int k = 0; k < NENT; k++) code_sel |= masked[k];
  end

  assign fin_sel = |(hit_ent & fin_i);

  always_comb begin
    if (fin_sel)                dest_o = ST_FINAL;
    else if (code_sel != 2'b00) dest_o = seq_state_e'({1'b0, code_sel});
    else                        dest_o = cur_i;
  end
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_seq_pkg::*;
#(
  parameter int unsigned NCH = 3,
  localparam int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned NENT = NMID * NCH
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   arm_set_i,
  input  logic                   arm_clr_i,
  input  logic                   sw_trig_i,
  input  logic [NCH-1:0]         force_hit_i,
  input  logic [NCH-1:0]         tag_hit_i,
  input  logic [NCH-1:0]         brk_en_i,
  input  logic [NENT*CODE_W-1:0] nxt_code_i,
  input  logic [NENT-1:0]        nxt_fin_i,
  input  logic                   trace_align_i,
  output logic [2:0]             state_o,
  output logic                   trace_trig_o,
  output logic                   brk_req_o,
  output logic                   armed_o
);
  seq_state_e      st_q, st_d, route_dest;
  logic [NCH-1:0]  hit, seq_req, brk_hit;
  logic            win_valid;
  logic [IDXW-1:0] win_idx;
  logic            mid_act;
  logic            trig_q, trig_d, brk_q, brk_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c]     = force_hit_i[c] | tag_hit_i[c];
    assign brk_hit[c] = hit[c] & brk_en_i[c];
    assign seq_req[c] = hit[c] & ~brk_en_i[c];
  end

  dbg_seq_arb #(.NCH(NCH)) u_arb (
    .req_i       (seq_req),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  dbg_seq_route #(.NCH(NCH)) u_route (
    .cur_i       (st_q),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .code_i      (nxt_code_i),
    .fin_i       (nxt_fin_i),
    .dest_o      (route_dest)
  );

  assign mid_act = (st_q == ST_ONE) || (st_q == ST_TWO) || (st_q == ST_THREE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (arm_set_i) st_d = ST_ONE;
      ST_ONE, ST_TWO, ST_THREE:
                st_d = sw_trig_i ? ST_FINAL : route_dest;
      ST_FINAL: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (arm_clr_i) st_d = ST_IDLE;
  end

  // trace trigger on entry (align low) or on the following cycle (align high)
  assign trig_d = trace_align_i ? (st_q == ST_FINAL)
                                : (st_d == ST_FINAL && st_q != ST_FINAL);
  assign brk_d  = mid_act && (|brk_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      trig_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      trig_q <= trig_d;
      brk_q  <= brk_d;
    end
  end

  assign state_o      = st_q;
  assign armed_o      = (st_q != ST_IDLE);
  assign trace_trig_o = trig_q;
  assign brk_req_o    = brk_q;
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk #(
  parameter int unsigned NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           arm_set_i,
  input logic           arm_clr_i,
  input logic           sw_trig_i,
  input logic [NCH-1:0] force_hit_i,
  input logic [NCH-1:0] tag_hit_i,
  input logic [NCH-1:0] brk_en_i,
  input logic [2:0]     state_o,
  input logic           trace_trig_o,
  input logic           brk_req_o
);
  logic mid;
  assign mid = (state_o == 3'd1) || (state_o == 3'd2) || (state_o == 3'd3);

  a_r1_arm_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && arm_set_i && !arm_clr_i) |=> (state_o == 3'd1));

  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && !arm_set_i) |=> (state_o == 3'd0));

  a_r3_final_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |=> (state_o == 3'd0));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_clr_i |=> (state_o == 3'd0));

  a_r6_sw_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid && sw_trig_i && !arm_clr_i) |=> (state_o == 3'd4));

  a_r8_brk_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid && |((force_hit_i | tag_hit_i) & brk_en_i)) |=> brk_req_o);

  a_r8_brk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mid) |=> !brk_req_o);

  a_r9_legal_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

  a_r10_trig_near_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_trig_o |-> (state_o == 3'd4 || $past(state_o) == 3'd4));
endmodule

bind dbg_seq dbg_seq_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dbg_seq_tb.sv
`timescale 1ns/1ps
module dbg_seq_tb;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_set = 0, arm_clr = 0, sw_trig = 0, align = 0;
  logic [NCH-1:0] force_hit = '0, tag_hit = '0, brk_en = '0;
  logic [3*NCH*2-1:0] cfg_code = '0;
  logic [3*NCH-1:0]   cfg_fin = '0;
  logic [2:0] state;
  logic trig, brk, armed;

  int n_chk = 0, n_fail = 0;
  int m_st = 0;
  string req = "R9";

  always #2.5 clk = ~clk;

  dbg_seq #(.NCH(NCH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_set_i(arm_set), .arm_clr_i(arm_clr),
    .sw_trig_i(sw_trig), .force_hit_i(force_hit), .tag_hit_i(tag_hit),
    .brk_en_i(brk_en), .nxt_code_i(cfg_code), .nxt_fin_i(cfg_fin),
    .trace_align_i(align), .state_o(state), .trace_trig_o(trig),
    .brk_req_o(brk), .armed_o(armed)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_next(int s);
    int hit;
    if (arm_clr) return 0;
    if (s == 0) return arm_set ? 1 : 0;
    if (s == 4) return 0;
    if (sw_trig) return 4;                       // R6
    for (int c = 0; c < NCH; c++) begin          // R5 lowest channel first
      hit = force_hit[c] | tag_hit[c];           // R7
      if (hit && !brk_en[c]) begin               // R8 excluded
        int e = (s - 1) * NCH + c;
        if (cfg_fin[e]) return 4;                // R2
        if (cfg_code[e*2 +: 2] != 0) return int'(cfg_code[e*2 +: 2]);
        return s;
      end
    end
    return s;
  endfunction

  task automatic cyc();
    int nx, e_trig, e_brk;
    nx = model_next(m_st);
    e_brk = (m_st >= 1 && m_st <= 3 && ((force_hit | tag_hit) & brk_en) != 0) ? 1 : 0;
    e_trig = align ? (m_st == 4) : (nx == 4 && m_st != 4);
    @(posedge clk);
    @(negedge clk);
    m_st = nx;
    chk("state", int'(state), m_st);
    chk("armed", int'(armed), (m_st != 0) ? 1 : 0);
    chk("trace_trig", int'(trig), e_trig);
    chk("brk_req", int'(brk), e_brk);
  endtask

  task automatic set_dest(int s, int c, int code, bit fin);
    cfg_code[((s-1)*NCH+c)*2 +: 2] = 2'(code);
    cfg_fin[(s-1)*NCH+c] = fin;
  endtask

  task automatic idle_in();
    arm_set = 0; arm_clr = 0; sw_trig = 0;
    force_hit = '0; tag_hit = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R9";
    chk("reset state", int'(state), 0);
    chk("reset armed", int'(armed), 0);
    chk("reset trig", int'(trig), 0);
    chk("reset brk", int'(brk), 0);
    rst_n = 1'b1;
    @(negedge clk);

    req = "R1"; cyc();                     // no arm: stays idle
    arm_set = 1; cyc(); idle_in();         // to state 1

    req = "R2";
    set_dest(1, 0, 2, 0); set_dest(2, 1, 3, 0); set_dest(3, 2, 1, 0);
    tag_hit = 3'b001; cyc(); idle_in();    // 1 -> 2
    req = "R7";
    force_hit = 3'b010; cyc(); idle_in();  // 2 -> 3 by forced hit
    req = "R2";
    tag_hit = 3'b100; cyc(); idle_in();    // 3 -> 1
    set_dest(1, 2, 0, 0);
    force_hit = 3'b100; cyc(); idle_in();  // stay in 1

    req = "R5";
    set_dest(1, 0, 3, 0); set_dest(1, 1, 2, 0);
    tag_hit = 3'b011; cyc(); idle_in();    // ch0 wins -> 3
    set_dest(3, 0, 0, 0); set_dest(3, 1, 2, 0);
    force_hit = 3'b011; cyc(); idle_in();  // ch0 stay wins, remain 3

    req = "R8";
    brk_en = 3'b001; set_dest(3, 1, 0, 1);
    tag_hit = 3'b011; cyc(); idle_in();    // brk from ch0, ch1 -> final
    req = "R3"; cyc();                     // final -> idle
    brk_en = '0;
    cyc();

    req = "R10"; align = 1;
    arm_set = 1; cyc(); idle_in();
    sw_trig = 1; force_hit = 3'b111; cyc(); idle_in();  // R6 override
    cyc(); cyc();
    align = 0;

    req = "R4";
    arm_set = 1; cyc(); idle_in();
    set_dest(1, 0, 2, 0); tag_hit = 3'b001; cyc(); idle_in();
    arm_clr = 1; sw_trig = 1; cyc(); idle_in();
    cyc();

    req = "R6";
    arm_set = 1; cyc(); idle_in();
    sw_trig = 1; cyc(); idle_in();
    cyc();

    req = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      arm_set   = ($urandom_range(0, 7) == 0);
      arm_clr   = ($urandom_range(0, 31) == 0);
      sw_trig   = ($urandom_range(0, 15) == 0);
      force_hit = NCH'($urandom_range(0, 7) & $urandom_range(0, 7));
      tag_hit   = NCH'($urandom_range(0, 7) & $urandom_range(0, 7));
      if ((i % 64) == 0) begin
        cfg_code = 18'($urandom);
        cfg_fin  = 9'($urandom) & 9'($urandom);
        brk_en   = NCH'($urandom_range(0, 7) & $urandom_range(0, 7));
        align    = 1'($urandom_range(0, 1));
      end
      cyc();
    end
    idle_in();
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule